// File: doc/BRIEF.md
# Expanded-Memory Bank Window Mapper

This block sits between an 8088-class CPU with a 20-bit address bus and its RAM. It places four 16 KB windows in the upper memory area, from 0xC0000 to 0xFFFFF. An access that falls inside an enabled window is redirected to a 16 KB page of physical RAM at or above 0xA0000. Every other access passes through untouched. Each window is programmed through two byte registers on the I/O bus. One register turns the window on and picks its page. The other contributes one bit to a shared 4-bit placement index, and that index decides where all four windows sit. The same index also decides whether the ROM extension region is switched on.

Translation is combinational. The block outputs the translated RAM address, a window-hit flag and a range-qualified write strobe, and it returns 0xFF for reads that land beyond the installed RAM. The register set answers only when the system is configured with more than 640 KB of RAM, which is given by a static configuration input.

Top module: `ems_window_mapper`

## Requirements
- R1: After reset every page register reads 0x7F. Control registers 0, 1 and 2 read 0x80 and control register 3 reads 0x00. No window translates, and the windows sit at 0xE0000, 0xE4000, 0xE8000 and 0xEC000.
- R2: An I/O address whose bits 13:1 equal 0x104 selects a register pair, with bits 15:14 giving the pair number. Bit 0 clear selects the page register and bit 0 set selects the control register.
- R3: Reading a page or control register returns the value last written to it. Reading any other I/O address returns 0xFF.
- R4: A window whose page register bit 7 is clear never hits. A CPU access with no hit appears on phys_addr_o as the CPU address, zero-extended.
- R5: A hit maps to 0xA0000 + (page[3:0] << 14) + (page[6] << 18) + CPU address[13:0]. Page bits 5:4 have no effect.
- R6: The placement index is built with control register i bit 7 at index bit i. Window i occupies 0x4000 bytes from 0xC0000 + i*0x4000 + (((index + 4 - i) & 0xC) << 14).
- R7: romext_en_o is 0 when the placement index is below 3 and 1 when it is 3 or more.
- R8: When phys_addr_o is at or above ram_limit_i, mem_rdata_o is 0xFF and ram_we_o stays 0. Below the limit, mem_rdata_o follows ram_rdata_i and ram_we_o follows mem_we_i.
- R9: With ram_big_i low, register writes are ignored and every I/O read returns 0xFF.
- R10: A register write accepted at a clock edge is already in effect for a memory access in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ram_big_i | input | 1 | Static: more than 640 KB of RAM installed |
| ram_limit_i | input | 21 | Installed RAM size in bytes |
| io_addr_i | input | 16 | I/O port address |
| io_wr_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data |
| mem_addr_i | input | 20 | CPU memory address |
| mem_we_i | input | 1 | CPU memory write |
| ram_rdata_i | input | 8 | Data read from RAM at phys_addr_o |
| phys_addr_o | output | 21 | Translated RAM address |
| win_hit_o | output | 1 | Access falls in an enabled window |
| ram_we_o | output | 1 | RAM write strobe, qualified by range |
| mem_rdata_o | output | 8 | Read data returned to the CPU |
| romext_en_o | output | 1 | ROM extension region enabled |

## Verification
A corrupted page register shows up on phys_addr_o in the first cycle after the write, but only when the CPU touches that window. A corrupted control bit moves every window at once and can flip romext_en_o, so probes just inside and just outside the expected window bases expose it in that same next cycle. The register readback path makes stored state visible on io_rdata_o without any memory access. That readback is the only place where the page bits that play no part in translation can be seen.

// File: rtl/ems_map_pkg.sv
package ems_map_pkg;
  localparam int NWIN     = 4;
  localparam int DW       = 8;
  localparam int IO_AW    = 16;
  localparam int WIN_SH   = 14;
  localparam int NUM_W    = 5;
  localparam int IDX_W    = NWIN;
  localparam logic [IO_AW-1:0] REG_PORT = 16'h0208;
  localparam logic [DW-1:0] PAGE_RST  = 8'h7F;
  localparam logic [DW-1:0] CTRL_ON   = 8'h80;
  localparam logic [DW-1:0] IDLE_DATA = 8'hFF;
  localparam int PAGE_ORG  = 'hA0000;
  localparam int ROMEXT_MIN = 3;
endpackage

// File: rtl/ems_regs.sv
module ems_regs
  import ems_map_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [IO_AW-1:0]     io_addr_i,
  input  logic                 io_wr_i,
  input  logic [DW-1:0]        io_wdata_i,
  output logic [DW-1:0]        io_rdata_o,
  output logic [NWIN-1:0]      win_en_o,
  output logic [NWIN*NUM_W-1:0] win_num_o,
  output logic [IDX_W-1:0]     base_idx_o
);
  localparam int GRP_W = $clog2(NWIN);

  logic [DW-1:0] page_q [NWIN];
  logic [DW-1:0] ctrl_q [NWIN];
  logic          sel;
  logic [GRP_W-1:0] grp;

  assign sel = en_i && (io_addr_i[13:1] == REG_PORT[13:1]);
  assign grp = io_addr_i[IO_AW-1 -: GRP_W];

  for (genvar g = 0; g < NWIN; g++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        page_q[g] <= PAGE_RST;
        ctrl_q[g] <= (g == NWIN-1) ? '0 : CTRL_ON;
      end else if (sel && io_wr_i && grp == GRP_W'(g)) begin
        if (io_addr_i[0]) ctrl_q[g] <= io_wdata_i;
        else              page_q[g] <= io_wdata_i;
      end
    end
    assign win_en_o[g]                = page_q[g][7];
    assign win_num_o[g*NUM_W +: NUM_W] = {page_q[g][6], page_q[g][3:0]};
    assign base_idx_o[g]              = ctrl_q[g][7];
  end

  always_comb begin
    io_rdata_o = IDLE_DATA;
    if (sel) io_rdata_o = io_addr_i[0] ? ctrl_q[grp] : page_q[grp];
  end
endmodule

// File: rtl/ems_window.sv
module ems_window
  import ems_map_pkg::*;
#(
  parameter int WIN_IDX = 0,
  parameter int CPU_AW  = 20,
  parameter int PHYS_AW = 21
) (
  input  logic               en_i,
  input  logic [NUM_W-1:0]   num_i,
  input  logic [IDX_W-1:0]   base_idx_i,
  input  logic [CPU_AW-1:0]  cpu_addr_i,
  output logic               hit_o,
  output logic [PHYS_AW-1:0] phys_o
);
  localparam int SLOT_W = CPU_AW - WIN_SH;
  logic [IDX_W-1:0]  sum;
  logic [SLOT_W-1:0] slot;

  // bits 3:2 of (index + 4 - i) pick the 64 KB bank, i picks the 16 KB slot in it
  assign sum  = base_idx_i + IDX_W'(NWIN - WIN_IDX);
  assign slot = {2'b11, sum[3:2], 2'(WIN_IDX)};
  assign hit_o = en_i && (cpu_addr_i[CPU_AW-1:WIN_SH] == slot);

  assign phys_o = PHYS_AW'(PAGE_ORG)
                + (PHYS_AW'(num_i[3:0]) << WIN_SH)
                + (PHYS_AW'(num_i[4]) << 18)
                + PHYS_AW'(cpu_addr_i[WIN_SH-1:0]);
endmodule

// File: rtl/ems_window_mapper.sv
module ems_window_mapper
  import ems_map_pkg::*;
#(
  parameter int CPU_AW  = 20,
  parameter int PHYS_AW = 21
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ram_big_i,
  input  logic [PHYS_AW-1:0] ram_limit_i,
  input  logic [IO_AW-1:0]   io_addr_i,
  input  logic               io_wr_i,
  input  logic [DW-1:0]      io_wdata_i,
  output logic [DW-1:0]      io_rdata_o,
  input  logic [CPU_AW-1:0]  mem_addr_i,
  input  logic               mem_we_i,
  input  logic [DW-1:0]      ram_rdata_i,
  output logic [PHYS_AW-1:0] phys_addr_o,
  output logic               win_hit_o,
  output logic               ram_we_o,
  output logic [DW-1:0]      mem_rdata_o,
  output logic               romext_en_o
);
  logic [NWIN-1:0]       win_en;
  logic [NWIN*NUM_W-1:0] win_num;
  logic [IDX_W-1:0]      base_idx;
  logic [NWIN-1:0]       hit;
  logic [PHYS_AW-1:0]    wphys [NWIN];
  logic                  in_ram;

  ems_regs u_regs (
    .clk_i, .rst_ni,
    .en_i      (ram_big_i),
    .io_addr_i, .io_wr_i, .io_wdata_i, .io_rdata_o,
    .win_en_o  (win_en),
    .win_num_o (win_num),
    .base_idx_o(base_idx)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    ems_window #(.WIN_IDX(w), .CPU_AW(CPU_AW), .PHYS_AW(PHYS_AW)) u_win (
      .en_i      (win_en[w]),
      .num_i     (win_num[w*NUM_W +: NUM_W]),
      .base_idx_i(base_idx),
      .cpu_addr_i(mem_addr_i),
      .hit_o     (hit[w]),
      .phys_o    (wphys[w])
    );
  end

  // lowest-numbered window wins
  always_comb begin
    phys_addr_o = PHYS_AW'(mem_addr_i);
    for (int w = NWIN-1; w >= 0; w--)
      if (hit[w]) phys_addr_o = wphys[w];
  end

  assign win_hit_o   = |hit;
  assign in_ram      = phys_addr_o < ram_limit_i;
  assign ram_we_o    = mem_we_i && in_ram;
  assign mem_rdata_o = in_ram ? ram_rdata_i : IDLE_DATA;
  assign romext_en_o = base_idx >= IDX_W'(ROMEXT_MIN);
endmodule

// File: rtl/ems_window_mapper_chk.sv
module ems_window_mapper_chk #(
  parameter int CPU_AW  = 20,
  parameter int PHYS_AW = 21
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ram_big_i,
  input logic [PHYS_AW-1:0] ram_limit_i,
  input logic [CPU_AW-1:0]  mem_addr_i,
  input logic               mem_we_i,
  input logic [PHYS_AW-1:0] phys_addr_o,
  input logic               win_hit_o,
  input logic               ram_we_o,
  input logic [7:0]         mem_rdata_o,
  input logic [7:0]         io_rdata_o
);
  p_pass_through_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_hit_o |-> phys_addr_o == PHYS_AW'(mem_addr_i));

  p_offset_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_hit_o |-> (phys_addr_o[13:0] == mem_addr_i[13:0]) && (phys_addr_o >= PHYS_AW'('hA0000)));

  p_hit_upper_area_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_hit_o |-> mem_addr_i[CPU_AW-1 -: 2] == 2'b11);

  p_no_write_oob_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> mem_we_i && (phys_addr_o < ram_limit_i));

  p_oob_reads_ff_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phys_addr_o >= ram_limit_i) |-> mem_rdata_o == 8'hFF);

  p_regs_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_big_i |-> io_rdata_o == 8'hFF);
endmodule

bind ems_window_mapper ems_window_mapper_chk #(.CPU_AW(CPU_AW), .PHYS_AW(PHYS_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ram_big_i(ram_big_i), .ram_limit_i(ram_limit_i),
  .mem_addr_i(mem_addr_i), .mem_we_i(mem_we_i), .phys_addr_o(phys_addr_o),
  .win_hit_o(win_hit_o), .ram_we_o(ram_we_o), .mem_rdata_o(mem_rdata_o),
  .io_rdata_o(io_rdata_o)
);

// File: tb/ems_window_mapper_tb_top.sv
module ems_window_mapper_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ram_big = 1;
  logic [20:0] ram_limit = 21'h100000;
  logic [15:0] io_addr = 0;
  logic        io_wr = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = 0;
  logic        mem_we = 0;
  logic [7:0]  ram_rdata = 8'h5A;
  logic [20:0] phys;
  logic        hit, ram_we, romext;
  logic [7:0]  mem_rdata;

  always #5 clk = ~clk;

  ems_window_mapper dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ram_big_i(ram_big), .ram_limit_i(ram_limit),
    .io_addr_i(io_addr), .io_wr_i(io_wr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .mem_addr_i(mem_addr), .mem_we_i(mem_we), .ram_rdata_i(ram_rdata),
    .phys_addr_o(phys), .win_hit_o(hit), .ram_we_o(ram_we),
    .mem_rdata_o(mem_rdata), .romext_en_o(romext)
  );

  typedef struct {
    string       tag;
    bit          is_io;
    logic [7:0]  rd;
    logic        hit;
    logic [20:0] phys;
    logic        rom;
    logic        we;
  } item_t;

  item_t sb[$];
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] pg [4];
  logic [7:0] ct [4];

  function automatic logic [7:0] exp_io(logic [15:0] a);
    if (!ram_big || a[13:1] != 13'h104) return 8'hFF;
    return a[0] ? ct[a[15:14]] : pg[a[15:14]];
  endfunction

  function automatic int idx_now();
    int v = 0;
    for (int i = 0; i < 4; i++) if (ct[i][7]) v += (1 << i);
    return v;
  endfunction

  task automatic model(input logic [19:0] a, output logic h, output logic [20:0] p);
    int base;
    h = 0; p = {1'b0, a};
    for (int i = 3; i >= 0; i--) begin
      base = 'hC0000 + i * 'h4000 + (((idx_now() + 4 - i) & 'hC) << 14);
      if (pg[i][7] && int'(a) >= base && int'(a) < base + 'h4000) begin
        h = 1;
        p = 21'('hA0000 + (int'(pg[i][3:0]) << 14) + (int'(pg[i][6]) << 18) + int'(a[13:0]));
      end
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1; mem_we = 0;
    if (ram_big && a[13:1] == 13'h104) begin
      if (a[0]) ct[a[15:14]] = d; else pg[a[15:14]] = d;
    end
  endtask

  task automatic io_read(input string tag, input logic [15:0] a);
    item_t it;
    @(negedge clk);
    io_wr = 0; io_addr = a;
    it.tag = tag; it.is_io = 1; it.rd = exp_io(a);
    it.hit = 0; it.phys = 0; it.rom = 0; it.we = 0;
    sb.push_back(it);
  endtask

  task automatic mem_probe(input string tag, input logic [19:0] a, input logic w);
    item_t it;
    logic h; logic [20:0] p; bit ok;
    @(negedge clk);
    io_wr = 0; mem_addr = a; mem_we = w;
    model(a, h, p);
    ok = p < ram_limit;
    it.tag = tag; it.is_io = 0; it.rd = ok ? ram_rdata : 8'hFF;
    it.hit = h; it.phys = p; it.rom = idx_now() >= 3; it.we = w && ok;
    sb.push_back(it);
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk); #2;
      while (sb.size() > 0) begin
        it = sb.pop_front();
        total++;
        if (it.is_io) begin
          if (io_rdata !== it.rd) begin
            bad++;
            $display("FAIL %s io_rdata act=%h exp=%h", it.tag, io_rdata, it.rd);
          end
        end else if (hit !== it.hit || phys !== it.phys || romext !== it.rom ||
                     ram_we !== it.we || mem_rdata !== it.rd) begin
          bad++;
          $display("FAIL %s act hit=%b phys=%h rom=%b we=%b rd=%h exp hit=%b phys=%h rom=%b we=%b rd=%h",
                   it.tag, hit, phys, romext, ram_we, mem_rdata,
                   it.hit, it.phys, it.rom, it.we, it.rd);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      pg[i] = 8'h7F; ct[i] = (i == 3) ? 8'h00 : 8'h80;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R2 pair selection
    for (int i = 0; i < 4; i++) begin
      io_read("R1 reset page", 16'(i << 14) | 16'h0208);
      io_read("R1 reset ctrl", 16'(i << 14) | 16'h0209);
    end
    mem_probe("R1 R4 R7 reset no hit", 20'hE0000, 0);
    // R3 unmapped ports
    io_read("R3 unmapped 020A", 16'h020A);
    io_read("R3 unmapped 1208", 16'h1208);
    // R5 R10 write then access next cycle
    io_write(16'h0208, 8'hC5);
    mem_probe("R5 R10 win0 page C5", 20'hE1234, 0);
    io_write(16'h4208, 8'h8A);
    mem_probe("R2 R5 win1 page 8A", 20'hE4010, 0);
    io_read("R2 R3 readback 4208", 16'h4208);
    io_write(16'h0208, 8'hBF);
    mem_probe("R5 bits 5:4 ignored", 20'hE3FFF, 0);
    io_write(16'hC208, 8'h30);
    mem_probe("R4 disabled win3", 20'hEC000, 0);
    // R6 R7 placement
    io_write(16'h8209, 8'h00);
    mem_probe("R7 index 3 boundary", 20'hE0ABC, 0);
    io_write(16'h4209, 8'h00);
    mem_probe("R6 R7 index 1 win0 at D0000", 20'hD0ABC, 0);
    mem_probe("R6 index 1 old base E0000 miss", 20'hE0ABC, 0);
    io_write(16'h0209, 8'h7F);
    mem_probe("R6 index 0 win0 at D0000", 20'hD3000, 0);
    io_write(16'hC209, 8'hFF);
    io_write(16'h4208, 8'h81);
    mem_probe("R6 index 8 win1", 20'hC4002, 0);
    mem_probe("R7 index 8", 20'hF0000, 0);
    io_read("R3 readback C209", 16'hC209);
    // R8 range limits
    ram_limit = 21'h0C0000;
    io_write(16'h0209, 8'h80);
    io_write(16'h0208, 8'hCF);
    mem_probe("R8 out of range write", 20'hF0100, 1);
    io_write(16'h0208, 8'h81);
    mem_probe("R8 in range write", 20'hF0100, 1);
    mem_probe("R8 passthrough above limit", 20'hC8000, 1);
    // R9 registers off when RAM small
    ram_big = 0;
    io_write(16'h0208, 8'h83);
    io_read("R9 read when disabled", 16'h0208);
    mem_probe("R9 ignored write keeps map", 20'hF0100, 0);
    ram_big = 1;
    io_read("R9 value kept", 16'h0208);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule